// File: doc/BRIEF.md
# A/D Converter Result and Control Register Interface

This block is the register side of a four-channel analog-to-digital converter. The converter loads four 16-bit conversion results through a wide write port, one strobe per channel. Software reads them over an 8-bit data path. A coherent 16-bit value comes from a two-access sequence. Reading the upper byte of a channel also copies that channel's lower byte into one shared holding latch. Any following lower-byte read then returns that latch, so both halves come from the same instant even if the converter reloads the register between the two accesses.

The block also holds an 8-bit control register. It has a two-bit trigger-mode field and a scan-select bit. The remaining bits are reserved and read as fixed constants. An external active-low trigger pin passes through a synchronizer and a falling-edge detector. When the trigger-mode field is 11, each detected falling edge produces a one-cycle conversion-start pulse. A standby input forces the control register back to its reset image.

Top module: `adc_regbus`

## Requirements
- R1: After reset every result register and the holding latch are zero, the control register reads 0x07 and `conv_start` is low.
- R2: Reads return data on `bus_rdata` one cycle after `bus_rd`, and `bus_rdata` holds until the next read. Addresses 0 to 7 select channel `addr[2:1]`, with `addr[0]`=0 the upper byte and 1 the lower byte. Address 8 is the control register and every other address reads 0x00. An upper-byte read returns bits 15:8 of the addressed result.
- R3: An upper-byte read copies bits 7:0 of the addressed result into the shared holding latch at the same clock edge.
- R4: A lower-byte read of any channel returns the holding latch, not the live lower byte, and leaves the latch unchanged.
- R5: Asserting `ld_strobe[n]` stores `ld_data` into result n at the next edge. A load never changes the holding latch. A read in the same cycle as a load of the same channel returns the value from before the load.
- R6: The control register reads as {mode[1:0], scan, 2'b00, 3'b111} at bits 7:6, 5, 4:3 and 2:0. A write to address 8 stores only `bus_wdata[7:5]`, and writes to bits 4:0 have no effect.
- R7: While `standby` is high the control register is forced to 0x07 at each edge, and writes in that cycle are ignored.
- R8: With trigger mode 00, 01 or 10, no activity on `trig_pin_n` produces `conv_start`.
- R9: With trigger mode 11, a falling edge on `trig_pin_n` first sampled at clock edge k raises `conv_start` after edge k+1. Rising edges produce nothing.
- R10: `conv_start` is high for exactly one cycle per detected falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Forces the control register to its reset image |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ld_strobe | input | 4 | Per-channel result load strobes |
| ld_data | input | 16 | Result value from the converter |
| trig_pin_n | input | 1 | Asynchronous external trigger, active falling edge |
| conv_start | output | 1 | One-cycle conversion-start pulse |
| trig_mode | output | 2 | Current trigger-mode field |
| scan_sel | output | 1 | Current scan-select bit |

## Verification
The assertions check the following on every cycle:
- the latch capture on upper-byte reads;
- latch stability on all other cycles;
- lower-byte reads returning the latch;
- the fixed reserved-bit image;
- the standby clear;
- the gating of `conv_start` by mode 11;
- the one-cycle width of `conv_start`.

The bench scenarios cover the rest:
- the exact two-edge trigger latency;
- the absence of a pulse on rising edges;
- the read-versus-load ordering within one cycle;
- the full sweep of all 256 control write values.

// File: rtl/adc_regbus_pkg.sv
package adc_regbus_pkg;
  localparam int BUS_W = 8;
  localparam logic [4:0] CTRL_FIXED = 5'b00111;
  localparam logic [1:0] MODE_FALL  = 2'b11;

  function automatic logic [BUS_W-1:0] ctrl_image(input logic [1:0] mode, input logic scan);
    return {mode, scan, CTRL_FIXED};
  endfunction

  function automatic logic trig_armed(input logic [1:0] mode);
    return mode == MODE_FALL;
  endfunction
endpackage

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NUM_CH = 4,
  parameter int RES_W  = 16,
  parameter int BUS_W  = 8,
  parameter int CH_W   = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_CH-1:0]              ld_strobe,
  input  logic [RES_W-1:0]               ld_data,
  input  logic                           hi_rd,
  input  logic [CH_W-1:0]                rd_ch,
  output logic [NUM_CH-1:0][RES_W-1:0]   res_q,
  output logic [BUS_W-1:0]               temp_q
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_res
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             res_q[ch] <= '0;
      else if (ld_strobe[ch]) res_q[ch] <= ld_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     temp_q <= '0;
    else if (hi_rd) temp_q <= res_q[rd_ch][BUS_W-1:0];
  end
endmodule

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       standby,
  input  logic       wr_en,
  input  logic [2:0] wbits,
  output logic [1:0] mode,
  output logic       scan
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= 2'b00;
      scan <= 1'b0;
    end else if (standby) begin
      mode <= 2'b00;
      scan <= 1'b0;
    end else if (wr_en) begin
      mode <= wbits[2:1];
      scan <= wbits[0];
    end
  end
endmodule

// File: rtl/adc_trig_detect.sv
module adc_trig_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic armed,
  output logic fall,
  output logic start
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b1;
        else        sync_q[0] <= pin_n;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[s] <= 1'b1;
        else        sync_q[s] <= sync_q[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign fall  = prev_q & ~sync_q[SYNC_STAGES-1];
  assign start = fall & armed;
endmodule

// File: rtl/adc_regbus.sv
module adc_regbus
  import adc_regbus_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int RES_W       = 16,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  standby,
  input  logic                  bus_rd,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [BUS_W-1:0]      bus_wdata,
  output logic [BUS_W-1:0]      bus_rdata,
  input  logic [NUM_CH-1:0]     ld_strobe,
  input  logic [RES_W-1:0]      ld_data,
  input  logic                  trig_pin_n,
  output logic                  conv_start,
  output logic [1:0]            trig_mode,
  output logic                  scan_sel
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(2 * NUM_CH);

  logic                         in_results;
  logic                         hi_rd;
  logic                         ctrl_wr;
  logic [CH_W-1:0]              rd_ch;
  logic [NUM_CH-1:0][RES_W-1:0] res_q;
  logic [BUS_W-1:0]             temp_q;
  logic [BUS_W-1:0]             sel_low;
  logic [BUS_W-1:0]             rd_next;
  logic                         trig_fall;
  logic [4:0]                   unused_wbits;

  assign in_results   = bus_addr < CTRL_ADDR;
  assign rd_ch        = bus_addr[CH_W:1];
  assign hi_rd        = bus_rd & in_results & ~bus_addr[0];
  assign ctrl_wr      = bus_wr & (bus_addr == CTRL_ADDR);
  assign sel_low      = res_q[rd_ch][BUS_W-1:0];
  assign unused_wbits = bus_wdata[4:0];

  adc_result_bank #(.NUM_CH(NUM_CH), .RES_W(RES_W), .BUS_W(BUS_W), .CH_W(CH_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .ld_strobe(ld_strobe), .ld_data(ld_data),
    .hi_rd(hi_rd), .rd_ch(rd_ch), .res_q(res_q), .temp_q(temp_q)
  );

  adc_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .standby(standby), .wr_en(ctrl_wr),
    .wbits(bus_wdata[7:5]), .mode(trig_mode), .scan(scan_sel)
  );

  adc_trig_detect #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk(clk), .rst_n(rst_n), .pin_n(trig_pin_n), .armed(trig_armed(trig_mode)),
    .fall(trig_fall), .start(conv_start)
  );

  always_comb begin
    rd_next = '0;
    if (in_results) begin
      if (bus_addr[0]) rd_next = temp_q;
      else             rd_next = res_q[rd_ch][RES_W-1:BUS_W];
    end else if (bus_addr == CTRL_ADDR) begin
      rd_next = ctrl_image(trig_mode, scan_sel);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/adc_regbus_chk.sv
module adc_regbus_chk #(
  parameter int ADDR_W = 4,
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              standby,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_rdata,
  input logic              hi_rd,
  input logic [7:0]        temp_q,
  input logic [7:0]        sel_low,
  input logic              trig_fall,
  input logic              conv_start,
  input logic [1:0]        trig_mode,
  input logic              scan_sel
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(2 * NUM_CH);
  logic lo_rd, ctrl_rd;
  assign lo_rd   = bus_rd && (bus_addr < CTRL_A) && bus_addr[0];
  assign ctrl_rd = bus_rd && (bus_addr == CTRL_A);

  p_hi_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hi_rd |=> temp_q == $past(sel_low));
  p_temp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_rd |=> $stable(temp_q));
  p_lo_from_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd |=> bus_rdata == $past(temp_q));
  p_ctrl_image_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd |=> (bus_rdata[4:0] == 5'b00111) && (bus_rdata[7:5] == {$past(trig_mode), $past(scan_sel)}));
  p_standby_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (trig_mode == 2'b00) && !scan_sel);
  p_gated_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (trig_mode == 2'b11) && trig_fall);
  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
endmodule

bind adc_regbus adc_regbus_chk #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .hi_rd(hi_rd), .temp_q(temp_q), .sel_low(sel_low),
  .trig_fall(trig_fall), .conv_start(conv_start), .trig_mode(trig_mode), .scan_sel(scan_sel)
);

// File: tb/tb_adc_regbus.sv
module tb_adc_regbus;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        standby = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [3:0]  ld_strobe = '0;
  logic [15:0] ld_data = '0;
  logic        trig_pin_n = 1'b1;
  logic        conv_start;
  logic [1:0]  trig_mode;
  logic        scan_sel;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_regbus dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic load(input int ch, input logic [15:0] v);
    @(negedge clk); ld_strobe = 4'(1 << ch); ld_data = v;
    @(negedge clk); ld_strobe = '0;
  endtask

  function automatic logic [15:0] pat(input int ch, input int p);
    return 16'((ch * 16'h1357) ^ (p * 16'h9B2D) ^ 16'hA5C3);
  endfunction

  initial begin
    logic [7:0] d;
    logic [15:0] v, oldv;
    int pulses;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 conv_start", 16'(conv_start), 16'h0);
    rd(4'd8, d); chk("R1 ctrl", 16'(d), 16'h07);
    for (int a = 0; a < 8; a++) begin rd(4'(a), d); chk("R1 result", 16'(d), 16'h0); end

    // R2 unmapped addresses
    for (int a = 9; a < 16; a++) begin rd(4'(a), d); chk("R2 unmapped", 16'(d), 16'h0); end

    // R2 R3 R4 sweep over channels and patterns
    for (int p = 0; p < 4; p++) begin
      for (int ch = 0; ch < 4; ch++) begin
        v = pat(ch, p);
        load(ch, v);
        rd(4'(2*ch), d);   chk("R2 high byte", 16'(d), 16'(v[15:8]));
        for (int o = 0; o < 4; o++) begin
          rd(4'(2*o+1), d); chk("R4 low via latch", 16'(d), 16'(v[7:0]));
        end
      end
    end

    // R5 load does not disturb latch
    v = 16'h1234; load(2, v); rd(4'd4, d); chk("R2 high", 16'(d), 16'h12);
    load(2, 16'hBEEF);
    rd(4'd5, d); chk("R5 latch kept", 16'(d), 16'h34);
    // R5 same-cycle load and high read returns old value
    oldv = 16'hBEEF;
    @(negedge clk); bus_rd = 1'b1; bus_addr = 4'd4; ld_strobe = 4'b0100; ld_data = 16'h7788;
    @(negedge clk); bus_rd = 1'b0; ld_strobe = '0; d = bus_rdata;
    chk("R5 old high", 16'(d), 16'(oldv[15:8]));
    rd(4'd5, d); chk("R5 old low", 16'(d), 16'(oldv[7:0]));
    rd(4'd4, d); chk("R5 new high", 16'(d), 16'h77);

    // R6 control write sweep
    for (int w = 0; w < 256; w++) begin
      wr(4'd8, 8'(w));
      rd(4'd8, d); chk("R6 ctrl image", 16'(d), 16'({w[7:5], 5'b00111}));
    end

    // R7 standby
    wr(4'd8, 8'hE0);
    @(negedge clk); standby = 1'b1;
    @(negedge clk); bus_wr = 1'b1; bus_addr = 4'd8; bus_wdata = 8'hFF;
    @(negedge clk); bus_wr = 1'b0; standby = 1'b0;
    rd(4'd8, d); chk("R7 standby clear", 16'(d), 16'h07);

    // R8 R9 R10 trigger modes
    for (int m = 0; m < 4; m++) begin
      wr(4'd8, 8'(m << 6));
      trig_pin_n = 1'b1; repeat (4) @(negedge clk);
      trig_pin_n = 1'b0;             // first sampled at edge k
      @(negedge clk); chk(m == 3 ? "R9 latency k" : "R8 idle", 16'(conv_start), 16'h0);
      @(negedge clk); chk(m == 3 ? "R9 pulse k+1" : "R8 no start", 16'(conv_start), 16'(m == 3));
      @(negedge clk); chk("R10 one cycle", 16'(conv_start), 16'h0);
      pulses = 0;
      repeat (4) begin @(negedge clk); pulses += int'(conv_start); end
      trig_pin_n = 1'b1;
      repeat (6) begin @(negedge clk); pulses += int'(conv_start); end
      chk("R9 R10 no extra pulse", 16'(pulses), 16'h0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule